// File: doc/BRIEF.md
# Host Port Status and Channel Interrupt Registers

This block is the software-visible status face of a full-speed USB host port. It keeps three 32-bit registers: a per-channel interrupt summary, a mask for that summary, and a port status register. The port status register shows the live connect and overcurrent levels and a port-enable bit. Each of these has a sticky change flag beside it. Connect and overcurrent arrive asynchronously and are synchronized inside the block. The port-enable grant comes from the port reset sequencer, and the sixteen channel interrupt lines come from the channel logic.

Software reaches the registers through a plain register port. A write strobe with address and data takes effect on that clock edge. A read strobe with an address loads the read-data register on that edge. Read data then holds until the next read. The change flags are cleared by writing 1 to them. The port-enable bit can be turned on only by hardware, and it can be turned off only by software writing 0. A single level interrupt output combines the unmasked channel summary with the three change flags.

Top module: `hport_regs`

## Requirements
- R1: After reset, all three registers read 0, read data is 0, and `irq_o` is low.
- R2: The summary register at offset 0x414 returns in bits 15:0 the channel lines as registered one clock earlier, with bit X for channel X. Bits 31:16 read 0. Writes to it have no effect.
- R3: The mask register at offset 0x418 is read/write in bits 15:0, and bits 31:16 read 0. A mask bit of 1 passes its channel and a 0 blocks it.
- R4: `irq_o` is high exactly when some summary bit is set with its mask bit at 1, or when status bit 1, 3 or 5 is set. It follows register state in the same cycle.
- R5: Status bit 0 at offset 0x440 shows the connect input after a two-flop synchronizer. A change on `connect_i` reaches bit 0 at the second clock edge.
- R6: Status bit 1 is set on the clock edge after synchronized connect rises, which is the third edge after `connect_i` rises. A falling connect does not set it. Writing 1 to it clears it and writing 0 leaves it. If a new connect event and a clearing write fall in the same cycle, the bit stays set.
- R7: Status bit 2 (port enable) is set on the edge where `en_grant_i` is high. A write with bit 2 = 1 does not set it. A write with bit 2 = 0 clears it, and that clear wins over a grant in the same cycle.
- R8: Status bit 3 is set one edge after bit 2 changes in either direction, and writing 1 clears it.
- R9: Status bit 4 shows the synchronized overcurrent input. Status bit 5 is set one edge after bit 4 changes in either direction, and writing 1 clears it.
- R10: Reads of any offset other than 0x414, 0x418 and 0x440 return 0. Writes to such offsets change no register.
- R11: `rdata_o` is loaded on the edge where `rd_en_i` is high, and it holds its value while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| connect_i | input | 1 | Asynchronous device-connected level |
| ovc_i | input | 1 | Asynchronous overcurrent level |
| en_grant_i | input | 1 | Port-enable set request from the reset sequencer |
| chan_irq_i | input | 16 | Per-channel interrupt request levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt level |

## Verification
Each input has a fixed arrival time in the results. Synchronized connect and overcurrent reach the status bits two edges after the input changes. The connect and overcurrent change flags follow one edge later. Port enable and the channel summary move on the first edge, and the enable change flag moves one edge after that. The `irq_o` level follows register state with no further delay, and read data shows register state as it stood just before the edge of the read. The bench samples one nanosecond after the edge it has counted to. It checks the third-edge connect timing cycle by cycle. For the other sticky results it waits a few edges before reading, so every read sees settled state. Same-cycle collisions are driven on purpose, so that the write strobe and the event land on the same edge.

// File: rtl/hport_pkg.sv
package hport_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CHAN_SUM  = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_CHAN_MASK = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_PORT_STAT = 12'h440;

  // Port status layout: field order sets bit positions 5..0.
  typedef struct packed {
    logic ovc_chg;   // bit 5
    logic ovc;       // bit 4
    logic en_chg;    // bit 3
    logic en;        // bit 2
    logic conn_chg;  // bit 1
    logic conn;      // bit 0
  } port_stat_t;

  localparam int STAT_W = $bits(port_stat_t);

endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hport_sticky.sv
module hport_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  // A new event outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= (flag_o & ~clr_i) | evt_i;
  end
endmodule

// File: rtl/hport_status.sv
module hport_status
  import hport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conn_s_i,
  input  logic              ovc_s_i,
  input  logic              en_grant_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wbits_i,
  output port_stat_t        stat_o
);
  port_stat_t wr_view;
  logic       conn_d, ovc_d, en_q, en_d;
  logic [2:0] evt, clr, flags;

  assign wr_view = port_stat_t'(wbits_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_d <= 1'b0;
      ovc_d  <= 1'b0;
      en_q   <= 1'b0;
      en_d   <= 1'b0;
    end else begin
      conn_d <= conn_s_i;
      ovc_d  <= ovc_s_i;
      en_d   <= en_q;
      if (wr_i && !wr_view.en) en_q <= 1'b0;   // software clear wins
      else if (en_grant_i)     en_q <= 1'b1;
    end
  end

  assign evt = {ovc_s_i ^ ovc_d, en_q ^ en_d, conn_s_i & ~conn_d};
  assign clr = wr_i ? {wr_view.ovc_chg, wr_view.en_chg, wr_view.conn_chg} : 3'b000;

  hport_sticky #(.W(3)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt),
    .clr_i (clr),
    .flag_o(flags)
  );

  always_comb begin
    stat_o          = '0;
    stat_o.conn     = conn_s_i;
    stat_o.conn_chg = flags[0];
    stat_o.en       = en_q;
    stat_o.en_chg   = flags[1];
    stat_o.ovc      = ovc_s_i;
    stat_o.ovc_chg  = flags[2];
  end
endmodule

// File: rtl/hport_chan.sv
module hport_chan #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] irq_i,
  input  logic           wr_mask_i,
  input  logic [NCH-1:0] wmask_i,
  output logic [NCH-1:0] sum_o,
  output logic [NCH-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o  <= '0;
      mask_o <= '0;
    end else begin
      sum_o <= irq_i;
      if (wr_mask_i) mask_o <= wmask_i;
    end
  end
endmodule

// File: rtl/hport_regs.sv
module hport_regs
  import hport_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              connect_i,
  input  logic              ovc_i,
  input  logic              en_grant_i,
  input  logic [NCH-1:0]    chan_irq_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int PAD_CH = DATA_W - NCH;
  localparam int PAD_ST = DATA_W - STAT_W;

  logic [1:0]        sync_q;
  logic [NCH-1:0]    sum, mask;
  port_stat_t        stat;
  logic [STAT_W-1:0] status_w;
  logic              hit_sum, hit_mask, hit_stat;
  logic [DATA_W-1:0] rd_mux;
  wire               unused_wdata = ^wdata_i;

  assign hit_sum  = (addr_i == OFS_CHAN_SUM);
  assign hit_mask = (addr_i == OFS_CHAN_MASK);
  assign hit_stat = (addr_i == OFS_PORT_STAT);

  hport_sync #(.W(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({ovc_i, connect_i}),
    .q_o  (sync_q)
  );

  hport_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .conn_s_i  (sync_q[0]),
    .ovc_s_i   (sync_q[1]),
    .en_grant_i(en_grant_i),
    .wr_i      (wr_en_i && hit_stat),
    .wbits_i   (wdata_i[STAT_W-1:0]),
    .stat_o    (stat)
  );

  hport_chan #(.NCH(NCH)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_i    (chan_irq_i),
    .wr_mask_i(wr_en_i && hit_mask),
    .wmask_i  (wdata_i[NCH-1:0]),
    .sum_o    (sum),
    .mask_o   (mask)
  );

  assign status_w = stat;

  always_comb begin
    rd_mux = '0;
    if (hit_sum)       rd_mux = {{PAD_CH{1'b0}}, sum};
    else if (hit_mask) rd_mux = {{PAD_CH{1'b0}}, mask};
    else if (hit_stat) rd_mux = {{PAD_ST{1'b0}}, status_w};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign irq_o = (|(sum & mask)) | stat.conn_chg | stat.en_chg | stat.ovc_chg;
endmodule

// File: rtl/hport_regs_chk.sv
module hport_regs_chk
  import hport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_grant_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [STAT_W-1:0] status
);
  p_flag_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] || status[3] || status[5]) |-> irq_o);

  p_conn_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |=> status[1]);

  p_en_hw_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(en_grant_i));

  p_en_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] != $past(status[2])) |=> status[3]);

  p_ovc_chg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] != $past(status[4])) |=> status[5]);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en_i) && $past(addr_i) != OFS_CHAN_SUM && $past(addr_i) != OFS_CHAN_MASK
     && $past(addr_i) != OFS_PORT_STAT) |-> (rdata_o == '0));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind hport_regs hport_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_grant_i(en_grant_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .status    (status_w)
);

// File: tb/hport_regs_tb.sv
`timescale 1ns/1ps
module hport_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        connect_i = 1'b0, ovc_i = 1'b0, en_grant_i = 1'b0;
  logic [15:0] chan_irq_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  localparam logic [11:0] A_SUM = 12'h414, A_MSK = 12'h418, A_ST = 12'h440;

  always #2.5 clk = ~clk;

  hport_regs u_dut (
    .clk(clk), .rst_n(rst_n), .connect_i(connect_i), .ovc_i(ovc_i),
    .en_grant_i(en_grant_i), .chan_irq_i(chan_irq_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en_i = 1'b1; addr_i = a;
    @(posedge clk); #1 d = rdata_o;
    @(negedge clk); rd_en_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rdata", rdata_o, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    rd(A_SUM, d); chk("R1 sum", d, 32'h0);
    rd(A_MSK, d); chk("R1 mask", d, 32'h0);
    rd(A_ST, d);  chk("R1 status", d, 32'h0);
  endtask

  task automatic t_chan();
    logic [31:0] d;
    @(negedge clk); chan_irq_i = 16'hA5A5;
    settle();
    rd(A_SUM, d); chk("R2 summary", d, 32'h0000A5A5);
    wr(A_SUM, 32'hFFFF_FFFF);
    rd(A_SUM, d); chk("R2 write ignored", d, 32'h0000A5A5);
    chk("R4 all masked", {31'h0, irq_o}, 32'h0);
    wr(A_MSK, 32'h0000_0002);
    chk("R4 masked-in idle channel", {31'h0, irq_o}, 32'h0);
    wr(A_MSK, 32'h0000_0100);
    chk("R4 unmasked pending channel", {31'h0, irq_o}, 32'h1);
    wr(A_MSK, 32'hFFFF_FFFF);
    rd(A_MSK, d); chk("R3 mask width", d, 32'h0000FFFF);
    @(negedge clk); chan_irq_i = 16'h0001;
    @(posedge clk); #1 chk("R2 one-edge latency", {31'h0, irq_o}, 32'h1);
    @(negedge clk); chan_irq_i = 16'h0000;
    @(posedge clk); #1 chk("R4 drop", {31'h0, irq_o}, 32'h0);
    wr(A_MSK, 32'h0000_1234);
    rd(A_MSK, d); chk("R3 readback", d, 32'h00001234);
    repeat (2) @(posedge clk); #1 chk("R11 hold", rdata_o, 32'h00001234);
    wr(A_MSK, 32'h0);
  endtask

  task automatic t_connect();
    logic [31:0] d;
    @(negedge clk); connect_i = 1'b1;
    @(posedge clk); @(posedge clk); #1 chk("R6 not yet at edge 2", {31'h0, irq_o}, 32'h0);
    @(posedge clk); #1 chk("R6 flag at edge 3", {31'h0, irq_o}, 32'h1);
    rd(A_ST, d); chk("R5 connect and flag", d, 32'h3);
    wr(A_ST, 32'h0);
    rd(A_ST, d); chk("R6 write 0 keeps", d, 32'h3);
    wr(A_ST, 32'h2);
    rd(A_ST, d); chk("R6 W1C", d, 32'h1);
    chk("R6 irq cleared", {31'h0, irq_o}, 32'h0);
    @(negedge clk); connect_i = 1'b0;
    settle();
    rd(A_ST, d); chk("R6 falling sets nothing", d, 32'h0);
    @(negedge clk); connect_i = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(A_ST, 32'h2);
    rd(A_ST, d); chk("R6 event beats clear", d, 32'h3);
    wr(A_ST, 32'h2);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    @(negedge clk); en_grant_i = 1'b1;
    @(negedge clk); en_grant_i = 1'b0;
    settle();
    rd(A_ST, d); chk("R7 R8 hw set", d, 32'hD);
    wr(A_ST, 32'hC);
    rd(A_ST, d); chk("R8 W1C keeps enable", d, 32'h5);
    wr(A_ST, 32'h0);
    settle();
    rd(A_ST, d); chk("R7 R8 sw clear", d, 32'h9);
    wr(A_ST, 32'h8);
    wr(A_ST, 32'h4);
    settle();
    rd(A_ST, d); chk("R7 sw cannot set", d, 32'h1);
    @(negedge clk); en_grant_i = 1'b1; wr_en_i = 1'b1; addr_i = A_ST; wdata_i = 32'h0;
    @(negedge clk); en_grant_i = 1'b0; wr_en_i = 1'b0;
    settle();
    rd(A_ST, d); chk("R7 clear beats grant", d, 32'h1);
  endtask

  task automatic t_ovc();
    logic [31:0] d;
    @(negedge clk); ovc_i = 1'b1;
    settle();
    rd(A_ST, d); chk("R9 ovc rise", d, 32'h31);
    wr(A_ST, 32'h20);
    rd(A_ST, d); chk("R9 W1C", d, 32'h11);
    @(negedge clk); ovc_i = 1'b0;
    settle();
    rd(A_ST, d); chk("R9 ovc fall", d, 32'h21);
    wr(A_ST, 32'h20);
    rd(A_ST, d); chk("R9 cleared", d, 32'h1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(12'h41C, 32'hFFFF_FFFF);
    wr(12'h444, 32'hFFFF_FFFF);
    rd(12'h41C, d); chk("R10 read 0x41C", d, 32'h0);
    rd(A_MSK, d);   chk("R10 mask untouched", d, 32'h0);
    rd(A_ST, d);    chk("R10 status untouched", d, 32'h1);
    rd(12'h400, d); chk("R10 read 0x400", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_chan();
    t_connect();
    t_enable();
    t_ovc();
    t_unmapped();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule